// File: doc/BRIEF.md
# Infrared Carrier Presence Detector

This block watches the output of an infrared receiver, sampled on its own clock, and decides whether a received burst is modulated onto a carrier or is a plain baseband envelope. After it is enabled, it times the first rising-edge-to-rising-edge interval and the first low stretch of the waveform, and compares both against a programmable detect threshold. A short first interval marks a carrier. The block then skips ahead and measures the carrier period between the third and fourth rising edges, which avoids the often distorted start of a burst. A long first low stretch, or a first interval that is not short, marks the waveform as carrier-free.

The result is one period register, in which zero stands for "no carrier". A one-cycle done pulse marks the end of classification. A valid level stays high from then until enable is dropped. There is exactly one result per enable window, so the result needs no back-pressure: the period register is plain status. It keeps its value until a later classification overwrites it.

Top module: `ir_carrier_detect`

## Requirements
- R1: The raw IR input is resynchronised through two flops before use. Only rising edges that occur after enable is asserted count. A level that is already high at enable, and any toggling while enable is low, produces no result.
- R2: When the first low stretch after the first counted rising edge lasts more than `thresh` sample cycles, classification ends with `period_o` = 0.
- R3: When the first low stretch is at most `thresh` and the interval from the first to the second rising edge is less than `thresh` cycles, `period_o` becomes the number of sample cycles from the third to the fourth rising edge.
- R4: When the first low stretch is at most `thresh` and the first rising-edge interval is `thresh` cycles or more, classification ends with `period_o` = 0.
- R5: Interval counters saturate at 2^CW-1 and never wrap, so an over-long third-to-fourth interval reports 2^CW-1.
- R6: `done_o` is a single-cycle pulse, given exactly once per enable window. `valid_o` rises with it and stays high while enable stays high.
- R7: `period_o` changes only in the cycle in which `done_o` is high. Outside that cycle it holds, and dropping enable does not change it.
- R8: Deasserting `en` returns the block to idle in the next cycle, clears `valid_o`, and discards any partial edge count. A measurement started after re-enabling starts from its own first edge.
- R9: After reset, `period_o` is 0 and `done_o` and `valid_o` are low. The value 0 in `period_o` is the encoding for "no carrier".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable. High starts or continues a detection; low returns the block to idle |
| ir_in | input | 1 | Raw receiver level, resynchronised inside the block |
| thresh | input | CW | Detect threshold in sample cycles |
| period_o | output | CW | Carrier period in sample cycles; 0 means no carrier |
| done_o | output | 1 | One-cycle pulse when classification completes |
| valid_o | output | 1 | High from completion until en falls |

## Verification
Several properties are checked on every cycle: that done is a one-cycle pulse accompanied by valid, that a low enable clears valid on the next edge, that the period register moves only in a done cycle, and that a saturated interval counter stays at its maximum. The carrier-versus-baseband decision is shown only by the bench's scenarios, which compute the expected period from the pulse widths they drive. These include threshold-equal boundaries on both the low stretch and the first interval, a third-to-fourth gap longer than the counter can hold, a high level present at enable, and an enable drop in mid-measurement.

// File: rtl/ir_cd_pkg.sv
package ir_cd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT1,
    ST_MEAS1,
    ST_WAIT3,
    ST_MEAS3,
    ST_DONE
  } cd_state_t;
endpackage

// File: rtl/ir_edge_sync.sv
module ir_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[LAST];
    end
  end

  assign lvl  = chain[LAST];
  assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/ir_sat_counter.sv
module ir_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= load_val;
    else if (inc && q != TOP) q <= q + 1'b1;
  end
endmodule

// File: rtl/ir_carrier_detect.sv
module ir_carrier_detect #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ir_in,
  input  logic [CW-1:0] thresh,
  output logic [CW-1:0] period_o,
  output logic          done_o,
  output logic          valid_o
);
  import ir_cd_pkg::*;

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  cd_state_t     state, state_nx;
  logic          lvl, rise, busy;
  logic          ivl_load, low_load;
  logic [CW-1:0] ivl_cnt, low_cnt;
  logic          finish;
  logic [CW-1:0] result;

  ir_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (ir_in), .lvl (lvl), .rise (rise)
  );

  assign busy     = (state != ST_IDLE);
  assign ivl_load = rise | ~busy;
  assign low_load = rise | ~busy;

  ir_sat_counter #(.W(CW)) u_ivl (
    .clk (clk), .rst_n (rst_n), .load (ivl_load),
    .load_val (busy ? ONE : ZERO), .inc (1'b1), .q (ivl_cnt)
  );

  ir_sat_counter #(.W(CW)) u_low (
    .clk (clk), .rst_n (rst_n), .load (low_load),
    .load_val (ZERO), .inc (~lvl), .q (low_cnt)
  );

  always_comb begin
    state_nx = state;
    finish   = 1'b0;
    result   = ZERO;
    case (state)
      ST_IDLE:  if (en) state_nx = ST_WAIT1;
      ST_WAIT1: if (rise) state_nx = ST_MEAS1;
      ST_MEAS1: begin
        if (low_cnt > thresh) begin
          finish   = 1'b1;
          state_nx = ST_DONE;
        end else if (rise) begin
          if (ivl_cnt < thresh) begin
            state_nx = ST_WAIT3;
          end else begin
            finish   = 1'b1;
            state_nx = ST_DONE;
          end
        end
      end
      ST_WAIT3: if (rise) state_nx = ST_MEAS3;
      ST_MEAS3: begin
        if (rise) begin
          finish   = 1'b1;
          result   = ivl_cnt;
          state_nx = ST_DONE;
        end
      end
      default: state_nx = state;
    endcase
    if (!en) begin
      state_nx = ST_IDLE;
      finish   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      period_o <= '0;
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      state  <= state_nx;
      done_o <= finish;
      if (finish) period_o <= result;
      if (!en) valid_o <= 1'b0;
      else if (finish) valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ir_carrier_detect_chk.sv
module ir_carrier_detect_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          done_o,
  input logic          valid_o,
  input logic [CW-1:0] period_o,
  input logic [CW-1:0] ivl_cnt,
  input logic          ivl_load
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_o);

  p_period_moves_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period_o) |-> done_o);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_cnt == TOP && !ivl_load) |=> ivl_cnt == TOP);
endmodule

bind ir_carrier_detect ir_carrier_detect_chk #(.CW(CW)) u_chk (
  .clk (clk), .rst_n (rst_n), .en (en), .done_o (done_o), .valid_o (valid_o),
  .period_o (period_o), .ivl_cnt (ivl_cnt), .ivl_load (ivl_load)
);

// File: tb/ir_carrier_detect_bench.sv
module ir_carrier_detect_bench;
  localparam int CW   = 16;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          ir_in = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic [CW-1:0] period_o;
  logic          done_o, valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ir_carrier_detect #(.CW(CW)) u_ir_carrier_detect (
    .clk (clk), .rst_n (rst_n), .en (en), .ir_in (ir_in), .thresh (thresh),
    .period_o (period_o), .done_o (done_o), .valid_o (valid_o)
  );

  always @(negedge clk) if (done_o) done_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_period(int th, int h1, int l1, int h3, int l3);
    int t3;
    if (l1 > th) return 0;
    if (h1 + l1 >= th) return 0;
    t3 = h3 + l3;
    return (t3 > MAXV) ? MAXV : t3;
  endfunction

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ir_in = v;
    end
  endtask

  task automatic run(input int th, input int pre, input int l0,
                     input int h1, input int l1, input int h2, input int l2,
                     input int h3, input int l3, input int h4, input int l4,
                     input string tag);
    int exp, d0;
    exp = exp_period(th, h1, l1, h3, l3);
    if (pre > 0) drive(1'b1, pre);
    @(negedge clk);
    thresh = CW'(th);
    en = 1'b1;
    d0 = done_cnt;
    if (pre > 0) drive(1'b1, 3);
    drive(1'b0, l0);
    drive(1'b1, h1); drive(1'b0, l1);
    drive(1'b1, h2); drive(1'b0, l2);
    drive(1'b1, h3); drive(1'b0, l3);
    drive(1'b1, h4); drive(1'b0, l4 + 6);
    check(period_o == CW'(exp), tag, int'(period_o), exp);
    check(valid_o == 1'b1, "R6 valid after done", int'(valid_o), 1);
    check(done_cnt - d0 == 1, "R6 one done pulse", done_cnt - d0, 1);
    @(negedge clk);
    en = 1'b0;
    drive(1'b0, 3);
    check(valid_o == 1'b0, "R8 valid cleared", int'(valid_o), 0);
    check(period_o == CW'(exp), "R7 period held", int'(period_o), exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int th, h1, l1, h2, l2, h3, l3, h4, l4, d0;
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(period_o == '0, "R9 reset period", int'(period_o), 0);
    check(valid_o == 1'b0, "R9 reset valid", int'(valid_o), 0);
    check(done_o == 1'b0, "R9 reset done", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 3);

    // R1 toggling while disabled gives nothing
    d0 = done_cnt;
    for (int k = 0; k < 6; k++) begin drive(1'b1, 2); drive(1'b0, 2); end
    check(done_cnt == d0, "R1 no done while disabled", done_cnt - d0, 0);
    check(valid_o == 1'b0, "R1 no valid while disabled", int'(valid_o), 0);

    // directed corners
    run(20, 0, 4, 3, 4, 3, 4, 5, 6, 3, 3, "R3 carrier basic");
    run(20, 0, 4, 10, 20, 3, 4, 5, 6, 3, 3, "R4 low equals thresh, T1 long");
    run(20, 0, 4, 2, 21, 3, 4, 5, 6, 3, 3, "R2 low exceeds thresh");
    run(20, 0, 4, 10, 9, 3, 4, 5, 6, 3, 3, "R3 T1 one below thresh");
    run(20, 0, 4, 10, 10, 3, 4, 5, 6, 3, 3, "R4 T1 equals thresh");
    run(20, 0, 4, 3, 200, 3, 4, 5, 6, 3, 3, "R9 long low gives zero");
    run(20, 6, 4, 3, 4, 2, 2, 7, 8, 3, 3, "R1 high at enable ignored");
    run(20, 0, 4, 3, 3, 3, 3, 40000, 30000, 2, 2, "R5 saturated period");

    // R8 abort mid-measurement
    @(negedge clk);
    thresh = CW'(30);
    en = 1'b1;
    d0 = done_cnt;
    drive(1'b0, 3);
    drive(1'b1, 2); drive(1'b0, 2); drive(1'b1, 2); drive(1'b0, 4);
    en = 1'b0;
    drive(1'b0, 3);
    check(done_cnt == d0, "R8 abort no done", done_cnt - d0, 0);
    check(valid_o == 1'b0, "R8 abort valid low", int'(valid_o), 0);
    check(period_o == CW'(MAXV), "R7 period kept over abort", int'(period_o), MAXV);
    run(30, 0, 3, 4, 4, 4, 4, 9, 2, 2, 2, "R8 fresh after abort");

    // constrained random
    for (int t = 0; t < 40; t++) begin
      th = 8 + int'($urandom_range(40));
      h1 = 1 + int'($urandom_range(24)); l1 = 1 + int'($urandom_range(24));
      h2 = 1 + int'($urandom_range(24)); l2 = 1 + int'($urandom_range(24));
      h3 = 1 + int'($urandom_range(24)); l3 = 1 + int'($urandom_range(24));
      h4 = 1 + int'($urandom_range(24)); l4 = 1 + int'($urandom_range(24));
      run(th, 0, 2 + int'($urandom_range(5)), h1, l1, h2, l2, h3, l3, h4, l4,
          "R3 R4 R2 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule